// File: doc/BRIEF.md
# Dual-Processor Interrupt Steering Controller

This block gathers interrupt requests from three kinds of origin: sixteen active-low external pins plus one active-low urgent pin, groups of internal peripheral request lines that are folded into one request per peripheral, and data-movement request lines that each stay separate. Every gathered source has an enable bit. An enabled, active source is sent either to the normal (IRQ) or to the fast (FIQ) output of a processor according to a per-source steering bit. A status word shows the enabled, active sources, and a vector word names the most urgent of them.

Two non-maskable inputs, one for each processor, are detected on their falling edge. An edge leaves a sticky pending bit that software clears. When the device is set up as an endpoint, any source can also be mapped onto one of four active-low PCI INTx pins. Software reaches all settings through a small read/write register port with a combinational read path.

Top module: `intctl_top`

## Requirements
- R1: After reset, irqOut, fiqOut and nmiOut are 0, pciIntN is 4'b1111, and every writable register and the vector read 0.
- R2: A source whose enable bit (address 0) is 0 never asserts irqOut, fiqOut or a pciIntN pin, and does not appear in the status word.
- R3: An enabled active source drives irqOut when its steering bit (address 1) is 0 and fiqOut when it is 1.
- R4: Source bit layout is 0..15 external pins 0..15, 16 the urgent pin, 17+p peripheral p, after those one bit per data-movement line. Peripheral p is active when any of its request lines periphReq[p*SUBS +: SUBS] is high.
- R5: The vector (address 6) is the source index plus 1 of the most urgent enabled active source, in the order urgent pin, external pin 15 down to 0, then internal sources by rising index. It reads 0 when none is active.
- R6: External and urgent pins are active when low.
- R7: Internal requests reach irqOut/fiqOut after one rising clock edge, external pins after three (two synchronizer stages plus the output register).
- R8: A falling edge on nmiN[n] sets pending bit n (address 7), which drives nmiOut[n]. Holding the pin low sets it only once. Writing 1 to bit n at address 7 clears it.
- R9: With the endpoint bit (address 8, bit 0) set, pciIntN[k] is low exactly when some enabled active source has its PCI mask bit (address 2) set and its 2-bit pin field equal to k. The pin field of source s sits at bits 2*(s%16)+1:2*(s%16) of address 3 + s/16.
- R10: With the endpoint bit clear, pciIntN stays 4'b1111.
- R11: The status word (address 5) equals the active sources ANDed with the enable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 4 | Register address |
| regWr | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr |
| xintN | input | 16 | External interrupt pins, active low |
| hpiN | input | 1 | Urgent external pin, active low |
| periphReq | input | 12 | Peripheral request lines, 3 per peripheral |
| dmaReq | input | 2 | Data-movement request lines |
| nmiN | input | 2 | Non-maskable inputs, one per processor |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |
| nmiOut | output | 2 | Non-maskable request per processor |
| pciIntN | output | 4 | PCI INTA..INTD, active low |

## Verification
Every source is made active on its own under an alternating steering pattern and rotating PCI pin fields. This isolates each bit position, the steering polarity and the pin mapping. Every pair of sources is then made active together, which checks every priority comparison in the vector. Sweeps with all sources active under partial and empty enable words separate masking from priority. Each request line of each peripheral separates correct merging from a wrong line grouping. Directed sequences on the non-maskable pins tell an edge detector apart from a level detector, and cycle-exact probes tell the internal latency apart from the synchronized external latency.

// File: rtl/intctl_pkg.sv
package intctl_pkg;

  typedef enum logic [3:0] {
    SEL_ENABLE   = 4'd0,
    SEL_STEER    = 4'd1,
    SEL_PCIMASK  = 4'd2,
    SEL_PINSEL0  = 4'd3,
    SEL_PINSEL1  = 4'd4,
    SEL_STATUS   = 4'd5,
    SEL_VECTOR   = 4'd6,
    SEL_NMI      = 4'd7,
    SEL_ENDPOINT = 4'd8,
    SEL_NONE     = 4'd15
  } regSel_e;

  typedef struct packed {
    logic       wrEnable;
    logic       wrSteer;
    logic       wrMask;
    logic [1:0] wrPinSel;
    logic       wrEndpoint;
    logic       clrNmi;
    regSel_e    rdSel;
  } strobe_t;

endpackage

// File: rtl/intctl_sync.sv
module intctl_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  // inactive-high pins: reset to 1 so no false edge appears
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '1;
      syncOut <= '1;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/intctl_ctrl.sv
module intctl_ctrl
  import intctl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  output strobe_t           stb
);
  always_comb begin
    stb          = '0;
    stb.rdSel    = SEL_NONE;
    case (regAddr)
      ADDR_W'(0): begin stb.rdSel = SEL_ENABLE;   stb.wrEnable    = regWr; end
      ADDR_W'(1): begin stb.rdSel = SEL_STEER;    stb.wrSteer     = regWr; end
      ADDR_W'(2): begin stb.rdSel = SEL_PCIMASK;  stb.wrMask      = regWr; end
      ADDR_W'(3): begin stb.rdSel = SEL_PINSEL0;  stb.wrPinSel[0] = regWr; end
      ADDR_W'(4): begin stb.rdSel = SEL_PINSEL1;  stb.wrPinSel[1] = regWr; end
      ADDR_W'(5): stb.rdSel = SEL_STATUS;
      ADDR_W'(6): stb.rdSel = SEL_VECTOR;
      ADDR_W'(7): begin stb.rdSel = SEL_NMI;      stb.clrNmi      = regWr; end
      ADDR_W'(8): begin stb.rdSel = SEL_ENDPOINT; stb.wrEndpoint  = regWr; end
      default:    stb.rdSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/intctl_dp.sv
module intctl_dp
  import intctl_pkg::*;
#(
  parameter int NUM_EXT    = 16,
  parameter int NUM_PERIPH = 4,
  parameter int SUBS       = 3,
  parameter int NUM_DMA    = 2,
  parameter int DATA_W     = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    stb,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  input  logic [NUM_EXT-1:0]         xintN,
  input  logic                       hpiN,
  input  logic [NUM_PERIPH*SUBS-1:0] periphReq,
  input  logic [NUM_DMA-1:0]         dmaReq,
  input  logic [1:0]                 nmiN,
  output logic                       irqOut,
  output logic                       fiqOut,
  output logic [1:0]                 nmiOut,
  output logic [3:0]                 pciIntN
);
  localparam int NSRC     = NUM_EXT + 1 + NUM_PERIPH + NUM_DMA;
  localparam int HPI_IDX  = NUM_EXT;
  localparam int PER_BASE = NUM_EXT + 1;
  localparam int VEC_W    = $clog2(NSRC + 1);
  localparam int PS_WORD  = DATA_W / 2;
  localparam int SYNC_W   = NUM_EXT + 3;

  initial begin
    if (NSRC > DATA_W) $error("source count exceeds data width");
  end

  // ---------------- pin synchronization ----------------
  logic [SYNC_W-1:0]  pinsS;
  logic [NUM_EXT-1:0] xintS;
  logic               hpiS;
  logic [1:0]         nmiS;

  intctl_sync #(.WIDTH(SYNC_W)) sync_i (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({nmiN, hpiN, xintN}),
    .syncOut(pinsS)
  );
  assign xintS = pinsS[NUM_EXT-1:0];
  assign hpiS  = pinsS[NUM_EXT];
  assign nmiS  = pinsS[NUM_EXT+2:NUM_EXT+1];

  // ---------------- source gathering ----------------
  logic [NUM_PERIPH-1:0] perAct;
  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_merge
    assign perAct[p] = |periphReq[p*SUBS +: SUBS];
  end

  logic [NSRC-1:0] srcAct;
  assign srcAct = {dmaReq, perAct, ~hpiS, ~xintS};

  // ---------------- configuration registers ----------------
  logic [NSRC-1:0] enableQ, steerQ, maskQ;
  logic [1:0]      pinSelQ [NSRC];
  logic            endpointQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ   <= '0;
      steerQ    <= '0;
      maskQ     <= '0;
      endpointQ <= 1'b0;
    end else begin
      if (stb.wrEnable)   enableQ   <= wrData[NSRC-1:0];
      if (stb.wrSteer)    steerQ    <= wrData[NSRC-1:0];
      if (stb.wrMask)     maskQ     <= wrData[NSRC-1:0];
      if (stb.wrEndpoint) endpointQ <= wrData[0];
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_pinsel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        pinSelQ[s] <= 2'd0;
      else if (stb.wrPinSel[s/PS_WORD]) pinSelQ[s] <= wrData[2*(s%PS_WORD) +: 2];
    end
  end

  // ---------------- status and priority ----------------
  logic [NSRC-1:0] status;
  logic [VEC_W-1:0] vecComb;
  assign status = srcAct & enableQ;

  always_comb begin
    vecComb = '0;
    // lowest urgency first; later hits overwrite earlier ones
    for (int i = NSRC - 1; i >= PER_BASE; i--)
      if (status[i]) vecComb = VEC_W'(i + 1);
    for (int i = 0; i < NUM_EXT; i++)
      if (status[i]) vecComb = VEC_W'(i + 1);
    if (status[HPI_IDX]) vecComb = VEC_W'(HPI_IDX + 1);
  end

  // ---------------- output registers ----------------
  logic [3:0] pciHit;
  always_comb begin
    pciHit = '0;
    for (int s = 0; s < NSRC; s++)
      if (status[s] && maskQ[s]) pciHit[pinSelQ[s]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut  <= 1'b0;
      fiqOut  <= 1'b0;
      pciIntN <= 4'hF;
    end else begin
      irqOut  <= |(status & ~steerQ);
      fiqOut  <= |(status & steerQ);
      pciIntN <= endpointQ ? ~pciHit : 4'hF;
    end
  end

  // ---------------- non-maskable edge capture ----------------
  logic [1:0] nmiPrev, nmiPend, nmiClr;
  assign nmiClr = stb.clrNmi ? wrData[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiPrev <= 2'b11;
      nmiPend <= 2'b00;
    end else begin
      nmiPrev <= nmiS;
      nmiPend <= (nmiPend & ~nmiClr) | (nmiPrev & ~nmiS);
    end
  end
  assign nmiOut = nmiPend;

  // ---------------- read mux ----------------
  logic [2*DATA_W-1:0] psFlat;
  always_comb begin
    psFlat = '0;
    for (int s = 0; s < NSRC; s++) psFlat[2*s +: 2] = pinSelQ[s];
  end

  always_comb begin
    case (stb.rdSel)
      SEL_ENABLE:   rdData = DATA_W'(enableQ);
      SEL_STEER:    rdData = DATA_W'(steerQ);
      SEL_PCIMASK:  rdData = DATA_W'(maskQ);
      SEL_PINSEL0:  rdData = psFlat[DATA_W-1:0];
      SEL_PINSEL1:  rdData = psFlat[2*DATA_W-1:DATA_W];
      SEL_STATUS:   rdData = DATA_W'(status);
      SEL_VECTOR:   rdData = DATA_W'(vecComb);
      SEL_NMI:      rdData = DATA_W'(nmiPend);
      SEL_ENDPOINT: rdData = DATA_W'(endpointQ);
      default:      rdData = '0;
    endcase
  end

  // ---------------- assertions ----------------
  a_r2_disabled_silent: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ == '0) |=> (!irqOut && !fiqOut));

  a_r3_irq_needs_normal: assert property (@(posedge clk) disable iff (!rstN)
    ((status & ~steerQ) == '0) |=> !irqOut);

  a_r3_fiq_needs_fast: assert property (@(posedge clk) disable iff (!rstN)
    ((status & steerQ) == '0) |=> !fiqOut);

  a_r10_pci_idle: assert property (@(posedge clk) disable iff (!rstN)
    !endpointQ |=> (pciIntN == 4'hF));

  a_r5_vec_none: assert property (@(posedge clk) disable iff (!rstN)
    (status == '0) |-> (vecComb == '0));

  a_r5_vec_points_active: assert property (@(posedge clk) disable iff (!rstN)
    (vecComb != '0) |-> |(status & (NSRC'(1) << (vecComb - VEC_W'(1)))));

  for (genvar n = 0; n < 2; n++) begin : g_nmi_chk
    a_r8_nmi_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (nmiPend[n] && !nmiClr[n]) |=> nmiPend[n]);
  end
endmodule

// File: rtl/intctl_top.sv
module intctl_top
  import intctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  regAddr,
  input  logic        regWr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic [15:0] xintN,
  input  logic        hpiN,
  input  logic [11:0] periphReq,
  input  logic [1:0]  dmaReq,
  input  logic [1:0]  nmiN,
  output logic        irqOut,
  output logic        fiqOut,
  output logic [1:0]  nmiOut,
  output logic [3:0]  pciIntN
);
  strobe_t stb;

  intctl_ctrl #(.ADDR_W(4)) ctrl_i (
    .regAddr(regAddr),
    .regWr  (regWr),
    .stb    (stb)
  );

  intctl_dp #(
    .NUM_EXT   (16),
    .NUM_PERIPH(4),
    .SUBS      (3),
    .NUM_DMA   (2),
    .DATA_W    (32)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .xintN    (xintN),
    .hpiN     (hpiN),
    .periphReq(periphReq),
    .dmaReq   (dmaReq),
    .nmiN     (nmiN),
    .irqOut   (irqOut),
    .fiqOut   (fiqOut),
    .nmiOut   (nmiOut),
    .pciIntN  (pciIntN)
  );
endmodule

// File: tb/intctl_top_tb_top.sv
module intctl_top_tb_top;
  localparam int NSRC = 23;
  localparam int NSUB = 3;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  regAddr;
  logic        regWr;
  logic [31:0] regWrData, regRdData;
  logic [15:0] xintN;
  logic        hpiN;
  logic [11:0] periphReq;
  logic [1:0]  dmaReq, nmiN, nmiOut;
  logic        irqOut, fiqOut;
  logic [3:0]  pciIntN;

  always #4 clk = ~clk;

  intctl_top dut_i (.*);

  int nChecks = 0;
  int nErr = 0;

  logic [NSRC-1:0] mEn, mSteer, mMask, mAct;
  logic [1:0]      mPin [NSRC];
  logic            mEp;

  task automatic chkEq(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWr = 1'b1; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic setCfg(logic [NSRC-1:0] en, logic [NSRC-1:0] st,
                        logic [NSRC-1:0] mk, logic ep);
    logic [31:0] w0, w1;
    mEn = en; mSteer = st; mMask = mk; mEp = ep;
    w0 = '0; w1 = '0;
    for (int s = 0; s < NSRC; s++)
      if (s < 16) w0[2*s +: 2] = mPin[s];
      else        w1[2*(s-16) +: 2] = mPin[s];
    wrReg(4'd0, 32'(en));
    wrReg(4'd1, 32'(st));
    wrReg(4'd2, 32'(mk));
    wrReg(4'd3, w0);
    wrReg(4'd4, w1);
    wrReg(4'd8, 32'(ep));
  endtask

  // drive a source pattern; sub picks which request line stands for a peripheral
  task automatic drive(logic [NSRC-1:0] act, int sub);
    @(negedge clk);
    mAct = act;
    xintN = ~act[15:0];
    hpiN  = ~act[16];
    periphReq = '0;
    for (int p = 0; p < 4; p++) if (act[17+p]) periphReq[p*NSUB + sub] = 1'b1;
    dmaReq = act[22:21];
    repeat (4) @(posedge clk);
  endtask

  function automatic logic [31:0] expVector(logic [NSRC-1:0] st);
    int ord [NSRC];
    ord[0] = 16;
    for (int k = 1; k <= 16; k++) ord[k] = 16 - k;
    for (int k = 17; k < NSRC; k++) ord[k] = k;
    for (int k = 0; k < NSRC; k++) if (st[ord[k]]) return 32'(ord[k] + 1);
    return 32'd0;
  endfunction

  task automatic checkAll(string tag);
    logic [31:0] d;
    logic [NSRC-1:0] st;
    logic [3:0] pe;
    st = mAct & mEn;
    pe = 4'hF;
    for (int s = 0; s < NSRC; s++)
      if (mEp && st[s] && mMask[s]) pe[mPin[s]] = 1'b0;
    rdReg(4'd5, d);
    chkEq({tag, " R11 R6 status"}, d, 32'(st));
    rdReg(4'd6, d);
    chkEq({tag, " R5 vector"}, d, expVector(st));
    chkEq({tag, " R3 irq"}, 32'(irqOut), 32'(|(st & ~mSteer)));
    chkEq({tag, " R3 fiq"}, 32'(fiqOut), 32'(|(st & mSteer)));
    chkEq({tag, " R9 pci"}, 32'(pciIntN), 32'(pe));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rstN = 1'b0; regAddr = '0; regWr = 1'b0; regWrData = '0;
    xintN = '1; hpiN = 1'b1; periphReq = '0; dmaReq = '0; nmiN = 2'b11;
    mAct = '0; mEn = '0; mSteer = '0; mMask = '0; mEp = 1'b0;
    for (int s = 0; s < NSRC; s++) mPin[s] = 2'(s % 4);
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    chkEq("R1 irq", 32'(irqOut), 0);
    chkEq("R1 fiq", 32'(fiqOut), 0);
    chkEq("R1 nmi", 32'(nmiOut), 0);
    chkEq("R1 pci", 32'(pciIntN), 32'hF);
    for (int a = 0; a < 9; a++) begin
      rdReg(4'(a), d);
      chkEq("R1 register", d, 0);
    end

    // every source alone
    setCfg('1, 23'h2AAAAA, '1, 1'b1);
    for (int s = 0; s < NSRC; s++) begin
      drive(NSRC'(1) << s, 0);
      checkAll("single R4");
    end

    // R7 latency, internal then external
    drive('0, 0);
    setCfg('1, '0, '0, 1'b0);
    @(negedge clk) dmaReq[0] = 1'b1;
    #1 chkEq("R7 internal before edge", 32'(irqOut), 0);
    @(negedge clk) chkEq("R7 internal one edge", 32'(irqOut), 1);
    dmaReq[0] = 1'b0;
    repeat (2) @(negedge clk);
    xintN[3] = 1'b0;
    repeat (2) @(negedge clk);
    chkEq("R7 external two edges", 32'(irqOut), 0);
    @(negedge clk) chkEq("R7 external three edges", 32'(irqOut), 1);
    xintN[3] = 1'b1;

    // every pair: priority
    setCfg('1, 23'h155555, '1, 1'b1);
    for (int a = 0; a < NSRC; a++)
      for (int b = a + 1; b < NSRC; b++) begin
        drive((NSRC'(1) << a) | (NSRC'(1) << b), (a + b) % NSUB);
        checkAll("pair R5");
      end

    // R4 every request line of every peripheral
    for (int p = 0; p < 4; p++)
      for (int u = 0; u < NSUB; u++) begin
        drive(NSRC'(1) << (17 + p), u);
        checkAll("merge R4");
      end

    // R2 enable masking with everything active
    setCfg('0, 23'h0F0F0F, '1, 1'b1);
    drive('1, 1);
    checkAll("none enabled R2");
    setCfg(23'h555555, 23'h0F0F0F, '1, 1'b1);
    drive('1, 2);
    checkAll("partial enable R2");

    // R10 endpoint off
    setCfg('1, '0, '1, 1'b0);
    drive('1, 0);
    checkAll("endpoint off R10");
    drive('0, 0);
    checkAll("idle R6");

    // R8 non-maskable edges
    @(negedge clk) nmiN[0] = 1'b0;
    repeat (4) @(negedge clk);
    chkEq("R8 nmi0 set", 32'(nmiOut), 32'b01);
    wrReg(4'd7, 32'b01);
    repeat (4) @(negedge clk);
    chkEq("R8 level held low ignored after clear", 32'(nmiOut), 0);
    nmiN[0] = 1'b1; nmiN[1] = 1'b0;
    repeat (4) @(negedge clk);
    chkEq("R8 nmi1 set, rising edge ignored", 32'(nmiOut), 32'b10);
    nmiN[0] = 1'b0;
    repeat (4) @(negedge clk);
    chkEq("R8 both set", 32'(nmiOut), 32'b11);
    wrReg(4'd7, 32'b10);
    rdReg(4'd7, d);
    chkEq("R8 clear one keeps other", d, 32'b01);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule